// File: doc/BRIEF.md
# Host-Bus Clock Divider and Run Control

This block sits between a fast host bus clock domain and a slow processor core that is advanced by a clock enable. A chain of toggle stages divides the host clock by four and yields a single-cycle enable pulse on every fourth host cycle. A short shift register stretches the host reset so the core reset lasts four cycles beyond the host reset.

The core may only execute once it has been brought online. Online is raised on the first divider pulse after the stretched reset has dropped. When the core reports halt while online, the block takes the core offline. One cycle later it registers a completion flag. The host sees the completion as `done`, and only while its read strobe is active. This keeps `done` from sitting high on the bus after the program ends. All pins are plain control and status signals; no data stream passes through the block.

Top module: `hbus_run_ctrl`

## Requirements
- R1: `core_ce` is a single-cycle pulse. While online it recurs exactly every four host cycles, with three low cycles between pulses.
- R2: Host reset clears both divider stages. Stage 0 inverts on every cycle. Stage 1 inverts only when stage 0 is 1. The enable tick is high when both stages are 1, so counting k host edges after reset release, the tick is high in cycles k = 3, 7, 11, and so on.
- R3: `core_rst` is high during host reset and for cycles k = 0..3 after release. It is low from k = 4 onward and does not rise again without a new host reset.
- R4: `online` is low during host reset. It rises in the cycle after the first tick seen with `core_rst` low, which is k = 8. `core_ce` is never high while `online` is low, so the first enable pulse is at k = 11.
- R5: If `core_halt` is sampled high while online, `online` is low from the next cycle and stays low until host reset, and `core_ce` stops. A halt seen while not online is ignored.
- R6: The completion flag is set one cycle after the halt is captured. If halt is sampled at the edge that ends cycle k, `done` can first be high in cycle k+2.
- R7: `done` is high only when the completion flag is set, `online` is low and `rd_strobe` is high. It follows `rd_strobe` cycle by cycle.
- R8: Host reset clears `online`, `done` and `core_ce` and restarts the divider and reset sequence from k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| host_rst | input | 1 | Host reset, active high, synchronous |
| rd_strobe | input | 1 | Host read strobe that qualifies `done` |
| core_halt | input | 1 | Halt indication from the core |
| core_ce | output | 1 | Core clock enable, one pulse per four host cycles while online |
| core_rst | output | 1 | Stretched reset to the core |
| online | output | 1 | Core is permitted to execute |
| done | output | 1 | Completion seen, qualified by the read strobe |

## Verification
The main sequence is driven with halt raised at three points. A halt before online must be ignored. A halt while running must drop `online` and stop the enable. A halt held high from reset release must let `online` rise for exactly one cycle and then fall. The read strobe is pulsed before halt, in the capture cycle and after the flag is set. This separates a one-cycle-late completion from an immediate one and from an unqualified one. Resets of different lengths are applied, one in mid-run and one after completion. They show that the four-cycle stretch, the enable phase and the cleared `done` restart exactly from the release edge.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    RC_WAIT = 2'd0,
    RC_RUN  = 2'd1,
    RC_HALT = 2'd2
  } run_state_e;
endpackage

// File: rtl/rc_clk_div.sv
module rc_clk_div #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] tog;

  // toggle input of each stage: stage 0 always, higher stages when all lower ones are set
  always_comb begin
    tog[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) tog[i] = tog[i-1] & q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q ^ tog;
  end

  assign tick = &q;

  // R1: after a tick the chain wraps to zero
  assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (q == '0));

  // R2: the first stage inverts on every cycle out of reset
  assert_stage0_flip_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q[0] != $past(q[0])));

  for (genvar i = 1; i < STAGES; i++) begin : g_stage_chk
    // R2: a higher stage changes only when all lower stages were set
    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (q[i] != $past(q[i]))) |-> $past(&q[i-1:0]));
  end
endmodule

// File: rtl/rc_rst_stretch.sv
module rc_rst_stretch #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  output logic rst_out
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[DEPTH-2:0], 1'b0};
  end

  assign rst_out = sr[DEPTH-1];

  // R3: host reset always drives the core reset
  assert_rst_follow_R3: assert property (@(posedge clk)
    rst |=> rst_out);

  // R3: core reset never falls in the cycle right after host reset
  assert_rst_stretch_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> !$past(rst));

  // R3: once low, core reset stays low without host reset
  assert_rst_stay_low_R3: assert property (@(posedge clk) disable iff (rst)
    !rst_out |=> !rst_out);
endmodule

// File: rtl/rc_run_fsm.sv
module rc_run_fsm
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic core_rst,
  input  logic core_halt,
  input  logic rd_strobe,
  output logic online,
  output logic done
);
  run_state_e state, state_nx;
  logic       cmpl_q;

  always_comb begin
    state_nx = state;
    case (state)
      RC_WAIT: if (tick && !core_rst) state_nx = RC_RUN;
      RC_RUN:  if (core_halt)         state_nx = RC_HALT;
      RC_HALT: state_nx = RC_HALT;
      default: state_nx = RC_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RC_WAIT;
      cmpl_q <= 1'b0;
    end else begin
      state  <= state_nx;
      cmpl_q <= (state == RC_HALT);
    end
  end

  assign online = (state == RC_RUN);
  assign done   = cmpl_q && !online && rd_strobe;

  // R4: online only rises after a tick seen with core reset released
  assert_online_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(online) |-> ($past(tick) && !$past(core_rst)));

  // R5: once halted the core stays offline
  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state == RC_HALT)) |-> !online);

  // R6: completion shows only after online was already low a cycle earlier
  assert_done_late_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(online));
endmodule

// File: rtl/hbus_run_ctrl.sv
module hbus_run_ctrl #(
  parameter int DIV_STAGES = 2,
  parameter int RST_STAGES = 4
) (
  input  logic clk,
  input  logic host_rst,
  input  logic rd_strobe,
  input  logic core_halt,
  output logic core_ce,
  output logic core_rst,
  output logic online,
  output logic done
);
  logic tick;

  rc_clk_div #(.STAGES(DIV_STAGES)) u_div (
    .clk  (clk),
    .rst  (host_rst),
    .tick (tick)
  );

  rc_rst_stretch #(.DEPTH(RST_STAGES)) u_stretch (
    .clk     (clk),
    .rst     (host_rst),
    .rst_out (core_rst)
  );

  rc_run_fsm u_fsm (
    .clk       (clk),
    .rst       (host_rst),
    .tick      (tick),
    .core_rst  (core_rst),
    .core_halt (core_halt),
    .rd_strobe (rd_strobe),
    .online    (online),
    .done      (done)
  );

  assign core_ce = tick & online;

  // R8: host reset leaves the core disabled and offline in the next cycle
  assert_reset_clear_R8: assert property (@(posedge clk)
    host_rst |=> (!core_ce && !online && !done));

  // R1: enable pulses last a single cycle
  assert_ce_single_R1: assert property (@(posedge clk) disable iff (host_rst)
    core_ce |=> !core_ce);
endmodule

// File: tb/hbus_run_ctrl_bench.sv
module hbus_run_ctrl_bench;
  logic clk = 1'b0;
  logic host_rst = 1'b1;
  logic rd_strobe = 1'b0;
  logic core_halt = 1'b0;
  logic core_ce, core_rst, online, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hbus_run_ctrl u_hbus_run_ctrl (
    .clk       (clk),
    .host_rst  (host_rst),
    .rd_strobe (rd_strobe),
    .core_halt (core_halt),
    .core_ce   (core_ce),
    .core_rst  (core_rst),
    .online    (online),
    .done      (done)
  );

  // row k (host edges since release): {rd, halt, exp_ce, exp_rst, exp_online, exp_done}
  localparam int NROWS = 18;
  localparam logic [5:0] VEC [NROWS] = '{
    6'b00_0100, // 0  core reset stretched
    6'b00_0100, // 1
    6'b00_0100, // 2
    6'b01_0100, // 3  tick while offline, halt ignored
    6'b00_0000, // 4  core reset drops
    6'b10_0000, // 5  read while offline before halt
    6'b00_0000, // 6
    6'b00_0000, // 7  tick enables entry
    6'b00_0010, // 8  online
    6'b10_0010, // 9  read while running
    6'b00_0010, // 10
    6'b00_1010, // 11 first enable
    6'b01_0010, // 12 halt raised
    6'b10_0000, // 13 offline, flag not yet set
    6'b10_0001, // 14 done with read
    6'b00_0000, // 15 tick suppressed, no read
    6'b10_0001, // 16 done follows read
    6'b00_0000  // 17
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // hold host reset for n edges, release at a falling edge: k = 0 afterwards
  task automatic apply_reset(input int n);
    @(negedge clk);
    host_rst = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    host_rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8 reset core_ce", core_ce, 1'b0);
    chk("R8 reset online", online, 1'b0);
    chk("R3 reset core_rst", core_rst, 1'b1);
    host_rst = 1'b0;

    // table walk
    for (int k = 0; k < NROWS; k++) begin
      rd_strobe = VEC[k][5];
      core_halt = VEC[k][4];
      #1;
      chk($sformatf("R1/R4 core_ce row %0d", k), core_ce, VEC[k][3]);
      chk($sformatf("R3 core_rst row %0d", k), core_rst, VEC[k][2]);
      chk($sformatf("R4/R5 online row %0d", k), online, VEC[k][1]);
      chk($sformatf("R6/R7 done row %0d", k), done, VEC[k][0]);
      @(negedge clk);
    end

    // R8: reset after completion clears done even with read held
    rd_strobe = 1'b1;
    core_halt = 1'b0;
    host_rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 done cleared", done, 1'b0);
    chk("R8 online cleared", online, 1'b0);
    chk("R3 core_rst in reset", core_rst, 1'b1);
    rd_strobe = 1'b0;

    // R1/R2: long free run, enable exactly at k>=11, k%4==3
    apply_reset(2);
    for (int k = 0; k < 60; k++) begin
      #1;
      chk($sformatf("R1/R2 core_ce run k=%0d", k), core_ce,
          (k >= 11) && ((k % 4) == 3));
      @(negedge clk);
    end

    // R8 mid-run reset, R3 long reset keeps stretch counted from release
    apply_reset(10);
    for (int k = 0; k < 6; k++) begin
      #1;
      chk($sformatf("R3 core_rst long k=%0d", k), core_rst, k < 4);
      chk($sformatf("R8 core_ce restart k=%0d", k), core_ce, 1'b0);
      @(negedge clk);
    end

    // R5/R6: halt held from release, online for one cycle only
    apply_reset(2);
    core_halt = 1'b1;
    rd_strobe = 1'b1;
    for (int k = 0; k < 13; k++) begin
      #1;
      chk($sformatf("R5 online halt-held k=%0d", k), online, k == 8);
      chk($sformatf("R6 done halt-held k=%0d", k), done, k >= 10);
      chk($sformatf("R5 core_ce halt-held k=%0d", k), core_ce, 1'b0);
      @(negedge clk);
    end
    rd_strobe = 1'b0;
    #1;
    chk("R7 done drops with read", done, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule